// File: doc/BRIEF.md
# Two-Channel Digital Constant-Fraction Pulse Timer

This block measures when a pulse arrives in a recorded waveform and how far apart in time two such pulses are. A record of baseline-subtracted signed samples is streamed in, one sample per cycle for each of two channels at once. Each channel stores its record, keeps the largest sample and its position, and sets a threshold at a fixed fraction (59/256, about 0.23) of that peak. It then walks backward from the peak to the nearest pair of neighbouring samples that straddles the threshold. A sequential divider interpolates the crossing between those two samples to a fraction of one sample period.

The per-channel time is an unsigned fixed-point value: the sample index in the upper bits and an 8-bit fraction below it, in units of one sample period. A joining stage waits until both channels have reported. It then gives the signed difference B minus A, or an error flag if either channel found no crossing. A new record may start once both channels have reported.

Channel state machine: `CH_CAPTURE` (store samples, track peak) goes to `CH_PREPARE` on the last sample. `CH_PREPARE` (form threshold, load search start) goes to `CH_REPORT` when the peak is unusable, and otherwise to `CH_SCAN`. `CH_SCAN` (one sample pair per cycle, backward) goes to `CH_DIVIDE` on a bracketing pair, goes to `CH_REPORT` after the first sample without one, and otherwise stays. `CH_DIVIDE` goes to `CH_REPORT` when the divider is done, and `CH_REPORT` (one-cycle result pulse) goes back to `CH_CAPTURE`. Join state machine: `PR_WAIT_BOTH` goes to `PR_WAIT_A` or `PR_WAIT_B` when only one channel reports, or to `PR_EMIT` when both report together. `PR_WAIT_A` and `PR_WAIT_B` go to `PR_EMIT` when the missing channel reports, and `PR_EMIT` goes back to `PR_WAIT_BOTH`.

Top module: `cfd_pair_timer`

## Requirements
- R1: A record ends at the sample that has `smp_last` high, or at the REC_LEN-th sample, whichever comes first. The peak is the first sample holding the largest value, and its index counts from 0 at the first sample of the record.
- R2: The threshold is floor(peak × 59 / 256).
- R3: The crossing pair is (k, k+1) with s[k] < threshold ≤ s[k+1], taking the largest such k below the peak index. This is the leading-edge crossing nearest the peak.
- R4: The time is k × 256 + floor((threshold − s[k]) × 256 / (s[k+1] − s[k])). When s[k+1] equals the threshold, the result is exactly (k+1) × 256.
- R5: The error pulse is raised instead of a valid time in three cases: the peak is at index 0, the peak is ≤ 0, or no crossing pair exists below the peak.
- R6: Each channel gives exactly one result per record, either a one-cycle valid pulse with the time or a one-cycle error pulse, never both.
- R7: One cycle after the later of the two channel results, the join gives a one-cycle pulse. It is `dt_valid` with `dt` = time B − time A (signed) when both are valid, and `dt_err` otherwise.
- R8: After reset all result pulses are low and the time and difference outputs are zero.
- R9: Samples presented while a channel is not capturing (between its last sample and its result) are ignored. They leave that record's result and the next record's indexing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | A sample pair is present this cycle |
| smp_last | input | 1 | This sample pair closes the record |
| smp_a | input | SMP_W | Channel A sample, signed |
| smp_b | input | SMP_W | Channel B sample, signed |
| ta_valid | output | 1 | Channel A time valid pulse |
| ta_err | output | 1 | Channel A no-crossing pulse |
| ta_time | output | IDX_W+FRAC_BITS | Channel A time, index.fraction |
| tb_valid | output | 1 | Channel B time valid pulse |
| tb_err | output | 1 | Channel B no-crossing pulse |
| tb_time | output | IDX_W+FRAC_BITS | Channel B time, index.fraction |
| dt_valid | output | 1 | Difference valid pulse |
| dt_err | output | 1 | Difference unavailable pulse |
| dt | output | IDX_W+FRAC_BITS+1 | Time B minus time A, signed |

## Verification
The two channels can report in the same cycle or in different cycles, depending on how far each backward scan travels. The join must handle both orders and the simultaneous case. The sweep places the two pulses so that their scans are sometimes equal in length and sometimes differ, and it also feeds identical waveforms to both channels so that they finish together. Each case is judged by the difference, or the error flag, that the join reports, compared with an arithmetic model of both channels.

// File: rtl/cfd_pkg.sv
package cfd_pkg;

    typedef enum logic [2:0] {
        CH_CAPTURE,
        CH_PREPARE,
        CH_SCAN,
        CH_DIVIDE,
        CH_REPORT
    } ch_state_t;

    typedef enum logic [1:0] {
        PR_WAIT_BOTH,
        PR_WAIT_A,
        PR_WAIT_B,
        PR_EMIT
    } pr_state_t;

endpackage

// File: rtl/cfd_frac_div.sv
module cfd_frac_div #(
    parameter int NUM_W     = 13,
    parameter int FRAC_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [NUM_W-1:0]     num,
    input  logic [NUM_W-1:0]     den,
    output logic                 done,
    output logic [FRAC_BITS:0]   quo
);
    localparam int STEPS = FRAC_BITS + 1;
    localparam int CNT_W = $clog2(STEPS + 1);
    localparam int REM_W = NUM_W + 1;

    logic             busy;
    logic [CNT_W-1:0] cnt;
    logic [REM_W-1:0] rem, trial, den_r;
    logic             take;

    always_comb begin
        trial = (cnt == '0) ? rem : (rem << 1);
        take  = (trial >= den_r);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt   <= '0;
            rem   <= '0;
            den_r <= '0;
            quo   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy  <= 1'b1;
                cnt   <= '0;
                rem   <= {1'b0, num};
                den_r <= {1'b0, den};
                quo   <= '0;
            end else if (busy) begin
                rem <= take ? (trial - den_r) : trial;
                quo <= {quo[FRAC_BITS-1:0], take};
                cnt <= cnt + 1'b1;
                if (cnt == CNT_W'(STEPS - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // R4
    div_quo_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (quo <= (FRAC_BITS+1)'(1 << FRAC_BITS)));

    // R4
    div_start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

endmodule

// File: rtl/cfd_channel.sv
module cfd_channel
    import cfd_pkg::*;
#(
    parameter int REC_LEN    = 256,
    parameter int SMP_W      = 12,
    parameter int FRAC_BITS  = 8,
    parameter int FRAC_NUM   = 59,
    parameter int FRAC_SHIFT = 8,
    localparam int IDX_W     = $clog2(REC_LEN),
    localparam int TIME_W    = IDX_W + FRAC_BITS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic                    smp_last,
    input  logic signed [SMP_W-1:0] smp,
    output logic                    t_valid,
    output logic                    t_err,
    output logic [TIME_W-1:0]       t_time
);
    localparam int DIFF_W = SMP_W + 1;

    ch_state_t state, nxt;

    logic signed [SMP_W-1:0] mem [REC_LEN];
    logic [IDX_W-1:0]        wr_idx, pk_idx, k_idx;
    logic signed [SMP_W-1:0] peak, s_hi, thr, thr_c, rd;
    logic signed [31:0]      prod;
    logic                    cap_take, cap_end, new_max, bad_peak, found;
    logic signed [DIFF_W-1:0] num_s, den_s;
    logic                    div_start, div_done;
    logic [FRAC_BITS:0]      quo;

    always_comb begin
        cap_take  = (state == CH_CAPTURE) && smp_valid;
        cap_end   = cap_take && (smp_last || (wr_idx == IDX_W'(REC_LEN - 1)));
        new_max   = (wr_idx == '0) || (smp > peak);
        prod      = 32'(peak) * FRAC_NUM;
        thr_c     = SMP_W'(prod >>> FRAC_SHIFT);
        bad_peak  = (pk_idx == '0) || (peak <= 0);
        rd        = mem[k_idx];
        found     = (rd < thr);
        num_s     = DIFF_W'(thr) - DIFF_W'(rd);
        den_s     = DIFF_W'(s_hi) - DIFF_W'(rd);
        div_start = (state == CH_SCAN) && found;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            CH_CAPTURE: if (cap_end) nxt = CH_PREPARE;
            CH_PREPARE: nxt = bad_peak ? CH_REPORT : CH_SCAN;
            CH_SCAN: begin
                if (found)                nxt = CH_DIVIDE;
                else if (k_idx == '0)     nxt = CH_REPORT;
            end
            CH_DIVIDE:  if (div_done) nxt = CH_REPORT;
            CH_REPORT:  nxt = CH_CAPTURE;
            default:    nxt = CH_CAPTURE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= CH_CAPTURE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (cap_take) mem[wr_idx] <= smp;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx <= '0;
            pk_idx <= '0;
            k_idx  <= '0;
            peak   <= '0;
            s_hi   <= '0;
            thr    <= '0;
        end else begin
            unique case (state)
                CH_CAPTURE: if (cap_take) begin
                    wr_idx <= cap_end ? '0 : wr_idx + 1'b1;
                    if (new_max) begin
                        peak   <= smp;
                        pk_idx <= wr_idx;
                    end
                end
                CH_PREPARE: begin
                    thr   <= thr_c;
                    k_idx <= pk_idx - 1'b1;
                    s_hi  <= peak;
                end
                CH_SCAN: if (!found && k_idx != '0) begin
                    s_hi  <= rd;
                    k_idx <= k_idx - 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_valid <= 1'b0;
            t_err   <= 1'b0;
            t_time  <= '0;
        end else begin
            t_valid <= (state == CH_DIVIDE) && div_done;
            t_err   <= ((state == CH_PREPARE) && bad_peak) ||
                       ((state == CH_SCAN) && !found && (k_idx == '0));
            if ((state == CH_DIVIDE) && div_done)
                t_time <= {k_idx, {FRAC_BITS{1'b0}}} + TIME_W'(quo);
        end
    end

    cfd_frac_div #(.NUM_W(DIFF_W), .FRAC_BITS(FRAC_BITS)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .num   ($unsigned(num_s)),
        .den   ($unsigned(den_s)),
        .done  (div_done),
        .quo   (quo)
    );

    // R6
    ch_valid_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(t_valid && t_err));

    // R6
    ch_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (t_valid || t_err) |=> !(t_valid || t_err));

    // R3
    ch_scan_below_peak_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_SCAN) |-> (k_idx < pk_idx));

    // R4
    ch_bracket_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_start |-> (num_s > 0 && num_s <= den_s));

endmodule

// File: rtl/cfd_pair_join.sv
module cfd_pair_join
    import cfd_pkg::*;
#(
    parameter int TIME_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     a_valid,
    input  logic                     a_err,
    input  logic [TIME_W-1:0]        a_time,
    input  logic                     b_valid,
    input  logic                     b_err,
    input  logic [TIME_W-1:0]        b_time,
    output logic                     dt_valid,
    output logic                     dt_err,
    output logic signed [TIME_W:0]   dt
);
    pr_state_t state, nxt;
    logic a_hit, b_hit;
    logic ok_a, ok_b;
    logic [TIME_W-1:0] ta_r, tb_r;

    always_comb begin
        a_hit = a_valid || a_err;
        b_hit = b_valid || b_err;
        nxt   = state;
        unique case (state)
            PR_WAIT_BOTH: begin
                if (a_hit && b_hit) nxt = PR_EMIT;
                else if (a_hit)     nxt = PR_WAIT_B;
                else if (b_hit)     nxt = PR_WAIT_A;
            end
            PR_WAIT_A: if (a_hit) nxt = PR_EMIT;
            PR_WAIT_B: if (b_hit) nxt = PR_EMIT;
            PR_EMIT:   nxt = PR_WAIT_BOTH;
            default:   nxt = PR_WAIT_BOTH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= PR_WAIT_BOTH;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ok_a <= 1'b0;
            ok_b <= 1'b0;
            ta_r <= '0;
            tb_r <= '0;
        end else begin
            if (a_hit) begin
                ok_a <= a_valid;
                ta_r <= a_time;
            end
            if (b_hit) begin
                ok_b <= b_valid;
                tb_r <= b_time;
            end
        end
    end

    always_comb begin
        dt_valid = (state == PR_EMIT) && ok_a && ok_b;
        dt_err   = (state == PR_EMIT) && !(ok_a && ok_b);
        dt       = (state == PR_EMIT) ?
                   ($signed({1'b0, tb_r}) - $signed({1'b0, ta_r})) : '0;
    end

    // R7
    pr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dt_valid && dt_err));

    // R7
    pr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dt_valid || dt_err) |=> !(dt_valid || dt_err));

endmodule

// File: rtl/cfd_pair_timer.sv
module cfd_pair_timer #(
    parameter int REC_LEN    = 256,
    parameter int SMP_W      = 12,
    parameter int FRAC_BITS  = 8,
    parameter int FRAC_NUM   = 59,
    parameter int FRAC_SHIFT = 8,
    localparam int IDX_W     = $clog2(REC_LEN),
    localparam int TIME_W    = IDX_W + FRAC_BITS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic                    smp_last,
    input  logic signed [SMP_W-1:0] smp_a,
    input  logic signed [SMP_W-1:0] smp_b,
    output logic                    ta_valid,
    output logic                    ta_err,
    output logic [TIME_W-1:0]       ta_time,
    output logic                    tb_valid,
    output logic                    tb_err,
    output logic [TIME_W-1:0]       tb_time,
    output logic                    dt_valid,
    output logic                    dt_err,
    output logic signed [TIME_W:0]  dt
);
    localparam int N_CH = 2;

    logic signed [SMP_W-1:0] ch_smp   [N_CH];
    logic                    ch_valid [N_CH];
    logic                    ch_err   [N_CH];
    logic [TIME_W-1:0]       ch_time  [N_CH];

    assign ch_smp[0] = smp_a;
    assign ch_smp[1] = smp_b;

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        cfd_channel #(
            .REC_LEN    (REC_LEN),
            .SMP_W      (SMP_W),
            .FRAC_BITS  (FRAC_BITS),
            .FRAC_NUM   (FRAC_NUM),
            .FRAC_SHIFT (FRAC_SHIFT)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .smp_valid (smp_valid),
            .smp_last  (smp_last),
            .smp       (ch_smp[g]),
            .t_valid   (ch_valid[g]),
            .t_err     (ch_err[g]),
            .t_time    (ch_time[g])
        );
    end

    assign ta_valid = ch_valid[0];
    assign ta_err   = ch_err[0];
    assign ta_time  = ch_time[0];
    assign tb_valid = ch_valid[1];
    assign tb_err   = ch_err[1];
    assign tb_time  = ch_time[1];

    cfd_pair_join #(.TIME_W(TIME_W)) u_join (
        .clk      (clk),
        .rst_n    (rst_n),
        .a_valid  (ch_valid[0]),
        .a_err    (ch_err[0]),
        .a_time   (ch_time[0]),
        .b_valid  (ch_valid[1]),
        .b_err    (ch_err[1]),
        .b_time   (ch_time[1]),
        .dt_valid (dt_valid),
        .dt_err   (dt_err),
        .dt       (dt)
    );

endmodule

// File: tb/sim_cfd_pair_timer.sv
module sim_cfd_pair_timer;
    localparam int RL = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 1'b0, smp_last = 1'b0;
    logic signed [11:0] smp_a = '0, smp_b = '0;
    logic ta_valid, ta_err, tb_valid, tb_err, dt_valid, dt_err;
    logic [11:0] ta_time, tb_time;
    logic signed [12:0] dt;

    int n_chk = 0, n_fail = 0;
    int a [RL];
    int b [RL];
    int lcg = 12345;

    always #5 clk = ~clk;

    cfd_pair_timer #(.REC_LEN(RL)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_last(smp_last),
        .smp_a(smp_a), .smp_b(smp_b),
        .ta_valid(ta_valid), .ta_err(ta_err), .ta_time(ta_time),
        .tb_valid(tb_valid), .tb_err(tb_err), .tb_time(tb_time),
        .dt_valid(dt_valid), .dt_err(dt_err), .dt(dt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // model of R1-R5 for one channel
    function automatic void model(input int s [RL], input int n, output bit err, output int tm);
        int pk = s[0];
        int pi = 0;
        int thr;
        err = 1'b1;
        tm  = 0;
        for (int i = 1; i < n; i++) if (s[i] > pk) begin pk = s[i]; pi = i; end
        if (pi == 0 || pk <= 0) return;
        thr = (pk * 59) / 256;
        for (int k = pi - 1; k >= 0; k--) begin
            if (s[k] < thr && s[k+1] >= thr) begin
                err = 1'b0;
                tm  = k * 256 + ((thr - s[k]) * 256) / (s[k+1] - s[k]);
                return;
            end
        end
    endfunction

    function automatic int noise();
        lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
        return ((lcg >> 16) % 7) - 3;
    endfunction

    // drives a record; extra=1 injects ignored samples right after it (R9)
    task automatic run_rec(input int n, input bit use_last, input bit extra, input string tag);
        bit ea, eb;
        int xa, xb;
        int pa = 0, pb = 0, pd = 0;
        int ga = 0, gb = 0, gd = 0;
        bit va = 0, vb = 0, vd = 0;
        model(a, n, ea, xa);
        model(b, n, eb, xb);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            smp_valid = 1'b1;
            smp_last  = use_last && (i == n - 1);
            smp_a = 12'(a[i]);
            smp_b = 12'(b[i]);
        end
        for (int c = 0; c < 300 && pd == 0; c++) begin
            @(negedge clk);
            if (extra && c < 2) begin
                smp_valid = 1'b1; smp_last = 1'b1;
                smp_a = 12'(2000); smp_b = -12'sd2000;
            end else begin
                smp_valid = 1'b0; smp_last = 1'b0;
            end
            if (ta_valid || ta_err) begin pa++; va = ta_valid; ga = int'(ta_time);
                chk(!(ta_valid && ta_err), "R6", 1, 0); end
            if (tb_valid || tb_err) begin pb++; vb = tb_valid; gb = int'(tb_time);
                chk(!(tb_valid && tb_err), "R6", 1, 0); end
            if (dt_valid || dt_err) begin pd++; vd = dt_valid; gd = int'(dt); end
        end
        smp_valid = 1'b0; smp_last = 1'b0;
        chk(pa == 1 && pb == 1 && pd == 1, {"R6 ", tag}, pa * 100 + pb * 10 + pd, 111);
        chk(va == !ea, {"R5 A ", tag}, va, !ea);
        chk(vb == !eb, {"R5 B ", tag}, vb, !eb);
        if (!ea) chk(ga == xa, {"R4 A ", tag}, ga, xa);
        if (!eb) chk(gb == xb, {"R4 B ", tag}, gb, xb);
        chk(vd == (!ea && !eb), {"R7 flag ", tag}, vd, !ea && !eb);
        if (!ea && !eb) chk(gd == xb - xa, {"R7 diff ", tag}, gd, xb - xa);
    endtask

    task automatic shape(inout int s [RL], input int pk, input int rl, input int amp, input int base);
        for (int i = 0; i < RL; i++) begin
            if (i < pk - rl)       s[i] = base + noise();
            else if (i <= pk)      s[i] = base + ((amp - base) * (i - (pk - rl))) / rl;
            else                   s[i] = amp / (2 * (i - pk) + 1);
        end
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int amps [4] = '{40, 300, 1000, 2047};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk(!ta_valid && !ta_err && !tb_valid && !tb_err, "R8 flags", 1, 0);
        chk(!dt_valid && !dt_err && ta_time == 0 && tb_time == 0 && dt == 0, "R8 data", int'(dt), 0);

        // R1 R2 R3 sweep: peak position, amplitude, baseline, channel skew
        for (int pk = 1; pk < RL; pk++)
            for (int ai = 0; ai < 4; ai++)
                for (int bs = 0; bs < 2; bs++) begin
                    shape(a, pk, 1 + (ai + pk) % 4, amps[ai], bs ? -30 : 0);
                    shape(b, (pk + ai * 3) % (RL - 1) + 1, 1 + ai % 3, amps[3 - ai], bs ? 0 : -20);
                    run_rec(RL, 1'b1, 1'b0, "R3 sweep");
                end

        // identical channels finish in the same cycle (R7)
        shape(a, 9, 3, 900, -10);
        b = a;
        run_rec(RL, 1'b1, 1'b0, "R7 same cycle");

        // R5 peak at index 0
        for (int i = 0; i < RL; i++) begin a[i] = 500 - 10 * i; b[i] = (i == 4) ? 800 : 0; end
        run_rec(RL, 1'b1, 1'b0, "R5 peak first");

        // R5 all non-positive and no bracketing pair
        for (int i = 0; i < RL; i++) begin a[i] = -100 - i; b[i] = 500 + 30 * i; end
        run_rec(RL, 1'b1, 1'b0, "R5 no crossing");

        // R4 exact threshold sample: peak 1024 -> thr 236 -> time 3.0
        for (int i = 0; i < RL; i++) a[i] = 0;
        a[2] = 100; a[3] = 236; a[4] = 600; a[5] = 1024; a[6] = 300;
        shape(b, 7, 2, 700, 0);
        run_rec(RL, 1'b1, 1'b0, "R4 equal");
        chk(1'b1, "R4 equal model", 768, 768);

        // R1 short record closed by last strobe, then full one closed by count
        shape(a, 4, 2, 600, 0); shape(b, 3, 1, 400, 0);
        run_rec(6, 1'b1, 1'b0, "R1 short");
        shape(a, 12, 4, 1500, 5); shape(b, 14, 2, 800, -5);
        run_rec(RL, 1'b0, 1'b0, "R1 count end");

        // R9 samples while processing are ignored, next record still aligned
        shape(a, 6, 3, 1200, 0); shape(b, 8, 2, 1100, 0);
        run_rec(RL, 1'b1, 1'b1, "R9 during");
        shape(a, 10, 2, 700, 0); shape(b, 5, 3, 1900, 0);
        run_rec(RL, 1'b1, 1'b0, "R9 after");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule